// File: doc/BRIEF.md
# Alarm-Triggered Power-Enable Controller

This block turns a board off at a chosen moment. Software loads a target calendar time, one BCD byte per field, into six alarm registers. It then sets an arm bit in a power-control register. The running calendar is not part of the block. It arrives as six BCD input fields. When the calendar becomes equal to the stored target in every field, the block records an alarm event in a status bit. If the arm bit is set at that moment, it also drives its `power_en` output low. The external power-management chip reads that low level as the request to switch the supply off.

The alarm event can also raise an interrupt, gated by one enable bit. The status bit is cleared by writing 1 to it. Once the output has switched off it stays off until reset, whatever software writes afterwards.

A three-state machine holds the power decision:
- `RUN_IDLE`: power on, not armed.
- `RUN_ARMED`: power on, armed.
- `PWR_OFF`: power off, latched.

Its transitions are:
- **arm**: `RUN_IDLE` to `RUN_ARMED`, taken when the arm bit is set.
- **disarm**: `RUN_ARMED` to `RUN_IDLE`, taken when the arm bit is cleared.
- **fire**: `RUN_IDLE` or `RUN_ARMED` to `PWR_OFF`, taken when the arm bit is set and an alarm event occurs in the same cycle.
- **hold**: `PWR_OFF` to itself, until reset.

Top module: `pwroff_alarm_ctrl`

## Requirements
- R1: After reset, `power_en` is 1 and `irq` is 0, and every register reads 0.
- R2: The alarm registers hold one 8-bit BCD field each, at these byte addresses:

  | Address | Field |
  |---------|-------|
  | 0x80 | seconds |
  | 0x84 | minutes |
  | 0x88 | hours |
  | 0x8C | day |
  | 0x90 | month |
  | 0x94 | year |

  A write stores `wdata[7:0]`. A read returns the stored byte, with bits 31:8 reading 0.
- R3: Bit 16 of the power-control register at address 0x98 is the arm bit. All other bits of that register read 0.
- R4: Bit 4 of the interrupt-enable register at address 0x48 enables the alarm interrupt. The register takes a full 32-bit write, so writing 0 clears the enable. All other bits read 0.
- R5: An alarm event occurs in a cycle where all six current-time inputs equal the stored alarm fields and they were not all equal in the previous cycle. The event sets bit 7 of the status register at address 0x44 at the next clock edge.
- R6: `irq` is 1 exactly while status bit 7 and interrupt-enable bit 4 are both 1.
- R7: When an alarm event occurs while the arm bit is 1, `power_en` goes to 0 at the same clock edge that sets the status bit.
- R8: An alarm event while the arm bit is 0 sets the status bit but leaves `power_en` at 1.
- R9: Once `power_en` is 0, it stays 0 until reset. Disarming, clearing the status bit, or a changing time does not bring it back.
- R10: Writing 1 to status bit 7 clears it. Writing 0 to that bit has no effect.
- R11: If an alarm event and a write-1-to-clear of the status bit fall in the same cycle, the status bit ends up set.
- R12: A match that is held for many cycles produces a single event. Once the status bit has been cleared, it stays 0 while the time keeps matching.
- R13: If any single field differs from its alarm value, no event occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_day | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| now_year | input | 8 | Current year, BCD |
| power_en | output | 1 | Power enable to the power-management chip; 0 requests off |
| irq | output | 1 | Alarm interrupt |

## Verification
The two actions that can coincide are the status update from a fresh alarm event and a software write-1-to-clear of that same status bit.

The bench provokes the collision directly. On one falling edge it changes the time inputs so that they match the alarm, and in the same cycle it raises a clear write to the status register. The clear is judged to have lost if the status bit reads 1 afterwards.

A second overlap is also driven: the arm bit being set at the moment of the match. In that case the check is that `power_en` falls on the very edge that sets the status bit.

// File: rtl/pwroff_pkg.sv
package pwroff_pkg;
    localparam int NFIELD   = 6;
    localparam int FIELD_W  = 8;
    localparam int DATA_W   = 32;
    localparam int REG_STAT = 'h44;
    localparam int REG_IEN  = 'h48;
    localparam int REG_ALM0 = 'h80;
    localparam int REG_PCTL = 'h98;
    localparam int STAT_BIT = 7;
    localparam int IEN_BIT  = 4;
    localparam int ARM_BIT  = 16;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_ARMED = 2'd1,
        PWR_OFF   = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/pwroff_regs.sv
module pwroff_regs
    import pwroff_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      evt,
    output logic [NFIELD*FIELD_W-1:0] alarm_flat,
    output logic                      arm_q,
    output logic                      ien_q,
    output logic                      stat_q,
    output logic [DATA_W-1:0]         rdata
);
    logic [FIELD_W-1:0] alm_q [NFIELD];
    logic               hit_stat, hit_ien, hit_pctl, stat_clr;
    logic               unused_wbits;

    assign unused_wbits = ^wdata;
    assign hit_stat = (addr == ADDR_W'(REG_STAT));
    assign hit_ien  = (addr == ADDR_W'(REG_IEN));
    assign hit_pctl = (addr == ADDR_W'(REG_PCTL));
    assign stat_clr = wr_en && hit_stat && wdata[STAT_BIT];

    for (genvar i = 0; i < NFIELD; i++) begin : g_alm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alm_q[i] <= '0;
            else if (wr_en && addr == ADDR_W'(REG_ALM0 + 4*i))
                alm_q[i] <= wdata[FIELD_W-1:0];
        end
        assign alarm_flat[i*FIELD_W +: FIELD_W] = alm_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q  <= 1'b0;
            ien_q  <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            if (wr_en && hit_pctl) arm_q <= wdata[ARM_BIT];
            if (wr_en && hit_ien)  ien_q <= wdata[IEN_BIT];
            if (evt)               stat_q <= 1'b1;
            else if (stat_clr)     stat_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_stat) rdata[STAT_BIT] = stat_q;
        if (hit_ien)  rdata[IEN_BIT]  = ien_q;
        if (hit_pctl) rdata[ARM_BIT]  = arm_q;
        for (int i = 0; i < NFIELD; i++)
            if (addr == ADDR_W'(REG_ALM0 + 4*i))
                rdata[FIELD_W-1:0] = alm_q[i];
    end
endmodule

// File: rtl/pwroff_match.sv
module pwroff_match
    import pwroff_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NFIELD*FIELD_W-1:0] alarm_flat,
    input  logic [NFIELD*FIELD_W-1:0] now_flat,
    output logic                      evt
);
    logic [NFIELD-1:0] eq;
    logic              match_now, match_prev_q;

    for (genvar i = 0; i < NFIELD; i++) begin : g_eq
        assign eq[i] = (alarm_flat[i*FIELD_W +: FIELD_W] == now_flat[i*FIELD_W +: FIELD_W]);
    end

    assign match_now = &eq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_prev_q <= 1'b1;
        else        match_prev_q <= match_now;
    end

    assign evt = match_now && !match_prev_q;
endmodule

// File: rtl/pwroff_fsm.sv
module pwroff_fsm
    import pwroff_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_q,
    input  logic       evt,
    output pwr_state_e st_q,
    output logic       power_en
);
    pwr_state_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RUN_IDLE: begin
                if (arm_q && evt) st_d = PWR_OFF;
                else if (arm_q)   st_d = RUN_ARMED;
            end
            RUN_ARMED: begin
                if (!arm_q)   st_d = RUN_IDLE;
                else if (evt) st_d = PWR_OFF;
            end
            PWR_OFF:  st_d = PWR_OFF;
            default:  st_d = RUN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RUN_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            PWR_OFF: power_en = 1'b0;
            default: power_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/pwroff_alarm_ctrl.sv
module pwroff_alarm_ctrl
    import pwroff_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [7:0]        now_sec,
    input  logic [7:0]        now_min,
    input  logic [7:0]        now_hour,
    input  logic [7:0]        now_day,
    input  logic [7:0]        now_mon,
    input  logic [7:0]        now_year,
    output logic              power_en,
    output logic              irq
);
    logic [NFIELD*FIELD_W-1:0] alarm_flat, now_flat;
    logic                      evt, arm_q, ien_q, stat_q;
    pwr_state_e                st_q;

    assign now_flat = {now_year, now_mon, now_day, now_hour, now_min, now_sec};

    pwroff_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .evt(evt), .alarm_flat(alarm_flat), .arm_q(arm_q), .ien_q(ien_q),
        .stat_q(stat_q), .rdata(rdata)
    );

    pwroff_match u_match (
        .clk(clk), .rst_n(rst_n), .alarm_flat(alarm_flat),
        .now_flat(now_flat), .evt(evt)
    );

    pwroff_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .arm_q(arm_q), .evt(evt),
        .st_q(st_q), .power_en(power_en)
    );

    assign irq = stat_q && ien_q;
endmodule

// File: rtl/pwroff_chk.sv
module pwroff_chk
    import pwroff_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       evt,
    input logic       arm_q,
    input logic       stat_q,
    input pwr_state_e st_q,
    input logic       power_en
);
    // R7
    armed_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && evt) |=> !power_en);

    // R9
    off_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !power_en |=> !power_en);

    // R8
    unarmed_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (power_en && !arm_q) |=> power_en);

    // R5
    evt_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> stat_q);

    // R10
    stat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !stat_q) |=> !stat_q);

    // R9
    state_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PWR_OFF) |=> (st_q == PWR_OFF));
endmodule

bind pwroff_alarm_ctrl pwroff_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt(evt), .arm_q(arm_q),
    .stat_q(stat_q), .st_q(st_q), .power_en(power_en)
);

// File: tb/sim_pwroff_alarm_ctrl.sv
module sim_pwroff_alarm_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00;
    logic [7:0]  now_day = 8'h01, now_mon = 8'h01, now_year = 8'hFF;
    logic        power_en, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwroff_alarm_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_day(now_day), .now_mon(now_mon), .now_year(now_year),
        .power_en(power_en), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_now(input logic [47:0] t);
        {now_year, now_mon, now_day, now_hour, now_min, now_sec} = t;
    endtask

    task automatic neutral();
        now_year = 8'hFF;
        tick();
    endtask

    task automatic load_alarm(input logic [47:0] t);
        for (int i = 0; i < 6; i++)
            wr(8'h80 + 8'(4*i), 32'hABCDEF00 | 32'(t[i*8 +: 8]));
    endtask

    function automatic logic [7:0] rbcd(input int lo, input int hi);
        int v;
        v = lo + int'($urandom % (hi - lo + 1));
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [47:0] rand_time();
        return {rbcd(0, 99), rbcd(1, 12), rbcd(1, 28), rbcd(0, 23), rbcd(0, 59), rbcd(0, 59)};
    endfunction

    function automatic logic [31:0] exp_stat(input logic hit);
        return hit ? 32'h80 : 32'h0;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [47:0] alm, t;
        logic        en, hit;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 power_en", 32'(power_en), 32'd1);
        chk("R1 irq", 32'(irq), 32'd0);
        rd(8'h44, v); chk("R1 status", v, 0);
        rd(8'h48, v); chk("R1 ien", v, 0);
        rd(8'h98, v); chk("R1 pctl", v, 0);
        rd(8'h80, v); chk("R1 alarm", v, 0);

        // R2 alarm readback
        alm = 48'h25_11_17_09_45_30;
        load_alarm(alm);
        for (int i = 0; i < 6; i++) begin
            rd(8'h80 + 8'(4*i), v);
            chk("R2 alarm field", v, 32'(alm[i*8 +: 8]));
        end

        // R3 control
        wr(8'h98, 32'hFFFFFFFF); rd(8'h98, v); chk("R3 arm set", v, 32'h10000);
        wr(8'h98, 32'h0);        rd(8'h98, v); chk("R3 arm clr", v, 0);

        // R4 enable, full write of zero clears
        wr(8'h48, 32'hFFFFFFFF); rd(8'h48, v); chk("R4 ien set", v, 32'h10);
        wr(8'h48, 32'h0);        rd(8'h48, v); chk("R4 ien clr", v, 0);

        // R5 R6 R8 R13 random
        for (int it = 0; it < 40; it++) begin
            neutral();
            alm = rand_time();
            load_alarm(alm);
            en = 1'($urandom % 2);
            wr(8'h48, en ? 32'h10 : 32'h0);
            wr(8'h44, 32'h80);
            t = alm;
            if ($urandom % 2 == 1) begin
                int k;
                k = int'($urandom % 6);
                t[k*8 +: 8] = t[k*8 +: 8] ^ (8'h1 << ($urandom % 4));
            end
            hit = (t == alm);
            set_now(t);
            tick();
            rd(8'h44, v);
            chk(hit ? "R5 status on match" : "R13 no event on mismatch", v, exp_stat(hit));
            chk("R6 irq", 32'(irq), 32'(hit && en));
            chk("R8 unarmed power_en", 32'(power_en), 32'd1);
        end

        // R12 held match, single event
        wr(8'h44, 32'h80);
        repeat (5) tick();
        rd(8'h44, v); chk("R12 held match no re-event", v, 0);

        // R10 write of zero ignored, write of one clears
        neutral();
        set_now(alm);
        tick();
        wr(8'h44, 32'h7F); rd(8'h44, v); chk("R10 zero write ignored", v, 32'h80);
        wr(8'h44, 32'h80); rd(8'h44, v); chk("R10 w1c", v, 0);

        // R11 event and clear together
        neutral();
        wr_en = 1'b1; addr = 8'h44; wdata = 32'h80;
        set_now(alm);
        tick();
        wr_en = 1'b0;
        rd(8'h44, v); chk("R11 set wins", v, 32'h80);
        chk("R11 power_en unarmed", 32'(power_en), 32'd1);

        // R7 armed match powers off
        wr(8'h44, 32'h80);
        neutral();
        wr(8'h98, 32'h10000);
        chk("R7 on before match", 32'(power_en), 32'd1);
        set_now(alm);
        tick();
        chk("R7 power_en off", 32'(power_en), 32'd0);
        rd(8'h44, v); chk("R7 status set", v, 32'h80);

        // R9 sticky until reset
        wr(8'h98, 32'h0);
        wr(8'h44, 32'h80);
        neutral();
        repeat (4) tick();
        chk("R9 stays off", 32'(power_en), 32'd0);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        chk("R9 on after reset", 32'(power_en), 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule